// File: doc/BRIEF.md
# Loop-Closing Branch Folder

This unit removes the cost of the branch at the bottom of a tight loop. It watches instructions as they retire. When a taken branch jumps backward by only a few halfwords, the unit records three things: where the branch sits, where it lands, and the instruction that follows the branch in memory. It then waits for the instruction at the landing address to retire and stores that instruction word as well.

From then on, whenever fetch reaches the recorded branch address, the unit hands the pipeline the stored loop-head instruction in place of the branch. The handed-over instruction is tagged with the loop-head address. In the same cycle the unit tells fetch to carry on from the word after the loop head, so each pass saves the two cycles a taken branch would otherwise cost.

The folded branch still resolves at retire. If it resolves untaken, the loop is over. The unit then gives fetch the fall-through address together with the saved fall-through instruction, and drops the entry. An external invalidate input clears the entry after any trap, interrupt, write to code space or other change of control flow.

Top module: `loop_fold_unit`

## Requirements
- R1: Out of reset the entry is empty: `inj_valid`, `redirect_valid` and `exit_valid` are 0, and no fetch address produces an injection.
- R2: A retiring branch is captured only if it is taken and its displacement is backward and short. The displacement `ret_disp` is a two's-complement count of 16-bit halfwords. It must lie in -MAX_BACK..-1, and its target, `ret_pc + 2*ret_disp`, must not wrap below address 0. Zero, forward and longer displacements are never captured.
- R3: An untaken branch is never captured, whatever its displacement.
- R4: After a capture, no injection occurs until an instruction retires at the target address. That instruction's `ret_instr` becomes the loop-head word, and the entry is armed on the following clock edge.
- R5: While armed, `fetch_valid` high with `fetch_pc` equal to the branch address gives, in the same cycle, `inj_valid`=1, `inj_instr` = loop-head word, `inj_pc` = target address, `redirect_valid`=1 and `redirect_pc` = target + 2.
- R6: No injection or redirect occurs when `fetch_valid` is low or when `fetch_pc` differs from the recorded branch address.
- R7: When the recorded branch retires untaken while armed, `exit_valid` is 1 for exactly one cycle after that retire edge, with `exit_pc` = branch address + 2 and `exit_instr` = the saved fall-through word. The entry is emptied at the same edge.
- R8: `flush_i` empties the entry at the next edge. It takes priority over a capture presented in the same cycle.
- R9: A qualifying branch at a different address replaces the entry and must relearn its loop head. A taken retire of the recorded branch leaves an armed entry armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Invalidate the entry |
| ret_valid | input | 1 | A retiring instruction is presented |
| ret_pc | input | AW | Address of the retiring instruction |
| ret_is_branch | input | 1 | Retiring instruction is a conditional branch |
| ret_taken | input | 1 | Branch resolved taken |
| ret_disp | input | DW | Branch displacement in halfwords, two's complement |
| ret_instr | input | IW | Word of the retiring instruction |
| ret_fall_instr | input | IW | Word following the retiring branch |
| fetch_valid | input | 1 | Fetch is requesting `fetch_pc` |
| fetch_pc | input | AW | Current fetch address |
| inj_valid | output | 1 | Substitute the loop-head word for the branch |
| inj_pc | output | AW | Address carried by the injected word |
| inj_instr | output | IW | Injected loop-head word |
| redirect_valid | output | 1 | Override the next fetch address |
| redirect_pc | output | AW | Next fetch address when redirecting |
| exit_valid | output | 1 | Loop left: resume at the fall-through |
| exit_pc | output | AW | Fall-through address |
| exit_instr | output | IW | Saved fall-through word |

## Verification
Injection and redirect are combinational from the stored entry and the fetch address. The bench therefore checks them a few nanoseconds after driving `fetch_pc` on the falling edge, in that same cycle. Capture, learning of the loop head, flush and exit each act through one register stage. Their effect is checked in the half-cycle after the next rising edge: through `exit_valid`, or by presenting the branch address to fetch and watching whether an injection appears. The one-cycle width of `exit_valid` is checked on the cycle that follows.

// File: rtl/loop_fold_pkg.sv
`timescale 1ns/1ps
package loop_fold_pkg;
  // Entry life cycle: nothing stored, branch stored but loop head unknown, ready to fold
  typedef enum logic [1:0] {
    ENT_EMPTY = 2'd0,
    ENT_LEARN = 2'd1,
    ENT_ARMED = 2'd2
  } ent_state_t;
endpackage

// File: rtl/fold_qualify.sv
`timescale 1ns/1ps
module fold_qualify #(
  parameter int AW       = 32,
  parameter int DW       = 8,
  parameter int MAX_BACK = 32
) (
  input  logic          ret_valid,
  input  logic          ret_is_branch,
  input  logic          ret_taken,
  input  logic [AW-1:0] ret_pc,
  input  logic [DW-1:0] ret_disp,
  output logic          qualify,
  output logic [AW-1:0] cap_target
);
  // Displacement in halfwords, widened with sign
  function automatic logic signed [31:0] disp_ext(input logic [DW-1:0] d);
    return 32'($signed(d));
  endfunction

  function automatic logic is_short_back(input logic [DW-1:0] d);
    logic signed [31:0] dx;
    dx = disp_ext(d);
    return (dx < 0) && (dx >= -MAX_BACK);
  endfunction

  // Byte address of the branch target
  function automatic logic [AW-1:0] target_of(input logic [AW-1:0] pc, input logic [DW-1:0] d);
    logic signed [AW-1:0] off;
    off = AW'($signed(d));
    return pc + AW'(off <<< 1);
  endfunction

  logic short_back;
  logic no_wrap;

  always_comb begin
    short_back = is_short_back(ret_disp);
    cap_target = target_of(ret_pc, ret_disp);
    no_wrap    = cap_target < ret_pc;
    qualify    = ret_valid && ret_is_branch && ret_taken && short_back && no_wrap;
  end
endmodule

// File: rtl/fold_entry.sv
`timescale 1ns/1ps
module fold_entry
  import loop_fold_pkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic          ret_valid,
  input  logic          ret_is_branch,
  input  logic          ret_taken,
  input  logic [AW-1:0] ret_pc,
  input  logic [IW-1:0] ret_instr,
  input  logic [IW-1:0] ret_fall_instr,
  input  logic          qualify,
  input  logic [AW-1:0] cap_target,
  output ent_state_t    state,
  output logic [AW-1:0] br_pc,
  output logic [AW-1:0] tgt_pc,
  output logic [IW-1:0] tgt_instr,
  output logic          exit_valid,
  output logic [AW-1:0] exit_pc,
  output logic [IW-1:0] exit_instr
);
  localparam int HW_BYTES = 2;

  function automatic logic [AW-1:0] next_pc(input logic [AW-1:0] pc);
    return pc + AW'(HW_BYTES);
  endfunction

  logic [IW-1:0] fall_instr;

  // Named events for the assertions
  logic same_branch, untaken_hit, confirm, capture, learn, exit_fire;

  always_comb begin
    same_branch = (state != ENT_EMPTY) && ret_valid && ret_is_branch && (ret_pc == br_pc);
    untaken_hit = same_branch && !ret_taken;
    confirm     = same_branch && ret_taken;
    capture     = qualify && !confirm;
    learn       = (state == ENT_LEARN) && ret_valid && (ret_pc == tgt_pc);
    exit_fire   = untaken_hit && !flush_i && (state == ENT_ARMED);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ENT_EMPTY;
      br_pc      <= '0;
      tgt_pc     <= '0;
      tgt_instr  <= '0;
      fall_instr <= '0;
      exit_valid <= 1'b0;
      exit_pc    <= '0;
      exit_instr <= '0;
    end else begin
      exit_valid <= exit_fire;
      if (exit_fire) begin
        exit_pc    <= next_pc(br_pc);
        exit_instr <= fall_instr;
      end
      if (flush_i || untaken_hit) begin
        state <= ENT_EMPTY;
      end else if (capture) begin
        state      <= ENT_LEARN;
        br_pc      <= ret_pc;
        tgt_pc     <= cap_target;
        fall_instr <= ret_fall_instr;
      end else if (learn) begin
        state     <= ENT_ARMED;
        tgt_instr <= ret_instr;
      end
    end
  end

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (state == ENT_EMPTY));

  assert_capture_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !flush_i) |=> (state == ENT_LEARN) && (br_pc == $past(ret_pc)) && (tgt_pc == $past(cap_target)));

  assert_target_behind_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ENT_EMPTY) |-> (tgt_pc < br_pc));

  assert_exit_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exit_valid |-> (state == ENT_EMPTY) && (exit_pc == br_pc + AW'(HW_BYTES)));

  assert_exit_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exit_valid |=> !exit_valid);

  assert_learn_arms_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (learn && !flush_i && !capture && !untaken_hit) |=> (state == ENT_ARMED) && (tgt_instr == $past(ret_instr)));
endmodule

// File: rtl/fold_inject.sv
`timescale 1ns/1ps
module fold_inject
  import loop_fold_pkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ent_state_t    state,
  input  logic [AW-1:0] br_pc,
  input  logic [AW-1:0] tgt_pc,
  input  logic [IW-1:0] tgt_instr,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_pc,
  output logic          inj_valid,
  output logic [AW-1:0] inj_pc,
  output logic [IW-1:0] inj_instr,
  output logic          redirect_valid,
  output logic [AW-1:0] redirect_pc
);
  localparam int HW_BYTES = 2;

  function automatic logic [AW-1:0] after_head(input logic [AW-1:0] pc);
    return pc + AW'(HW_BYTES);
  endfunction

  logic fold_hit;

  always_comb begin
    fold_hit       = (state == ENT_ARMED) && fetch_valid && (fetch_pc == br_pc);
    inj_valid      = fold_hit;
    inj_pc         = tgt_pc;
    inj_instr      = tgt_instr;
    redirect_valid = fold_hit;
    redirect_pc    = after_head(tgt_pc);
  end

  assert_inject_needs_fetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    inj_valid |-> fetch_valid && (fetch_pc != inj_pc));

  assert_redirect_past_head_R5: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> inj_valid && (redirect_pc <= fetch_pc));
endmodule

// File: rtl/loop_fold_unit.sv
`timescale 1ns/1ps
module loop_fold_unit
  import loop_fold_pkg::*;
#(
  parameter int AW       = 32,
  parameter int IW       = 16,
  parameter int DW       = 8,
  parameter int MAX_BACK = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic          ret_valid,
  input  logic [AW-1:0] ret_pc,
  input  logic          ret_is_branch,
  input  logic          ret_taken,
  input  logic [DW-1:0] ret_disp,
  input  logic [IW-1:0] ret_instr,
  input  logic [IW-1:0] ret_fall_instr,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_pc,
  output logic          inj_valid,
  output logic [AW-1:0] inj_pc,
  output logic [IW-1:0] inj_instr,
  output logic          redirect_valid,
  output logic [AW-1:0] redirect_pc,
  output logic          exit_valid,
  output logic [AW-1:0] exit_pc,
  output logic [IW-1:0] exit_instr
);
  logic          qualify;
  logic [AW-1:0] cap_target;
  ent_state_t    state;
  logic [AW-1:0] br_pc;
  logic [AW-1:0] tgt_pc;
  logic [IW-1:0] tgt_instr;

  fold_qualify #(.AW(AW), .DW(DW), .MAX_BACK(MAX_BACK)) u_qual (
    .ret_valid    (ret_valid),
    .ret_is_branch(ret_is_branch),
    .ret_taken    (ret_taken),
    .ret_pc       (ret_pc),
    .ret_disp     (ret_disp),
    .qualify      (qualify),
    .cap_target   (cap_target)
  );

  fold_entry #(.AW(AW), .IW(IW)) u_entry (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush_i       (flush_i),
    .ret_valid     (ret_valid),
    .ret_is_branch (ret_is_branch),
    .ret_taken     (ret_taken),
    .ret_pc        (ret_pc),
    .ret_instr     (ret_instr),
    .ret_fall_instr(ret_fall_instr),
    .qualify       (qualify),
    .cap_target    (cap_target),
    .state         (state),
    .br_pc         (br_pc),
    .tgt_pc        (tgt_pc),
    .tgt_instr     (tgt_instr),
    .exit_valid    (exit_valid),
    .exit_pc       (exit_pc),
    .exit_instr    (exit_instr)
  );

  fold_inject #(.AW(AW), .IW(IW)) u_inj (
    .clk           (clk),
    .rst_n         (rst_n),
    .state         (state),
    .br_pc         (br_pc),
    .tgt_pc        (tgt_pc),
    .tgt_instr     (tgt_instr),
    .fetch_valid   (fetch_valid),
    .fetch_pc      (fetch_pc),
    .inj_valid     (inj_valid),
    .inj_pc        (inj_pc),
    .inj_instr     (inj_instr),
    .redirect_valid(redirect_valid),
    .redirect_pc   (redirect_pc)
  );

  assert_fold_only_when_armed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    inj_valid |-> (state == ENT_ARMED) && (fetch_pc == br_pc));
endmodule

// File: tb/loop_fold_unit_test.sv
`timescale 1ns/1ps
module loop_fold_unit_test;
  localparam int AW = 32;
  localparam int IW = 16;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          flush_i = 1'b0;
  logic          ret_valid = 1'b0;
  logic [AW-1:0] ret_pc = '0;
  logic          ret_is_branch = 1'b0;
  logic          ret_taken = 1'b0;
  logic [DW-1:0] ret_disp = '0;
  logic [IW-1:0] ret_instr = '0;
  logic [IW-1:0] ret_fall_instr = '0;
  logic          fetch_valid = 1'b0;
  logic [AW-1:0] fetch_pc = '0;
  logic          inj_valid;
  logic [AW-1:0] inj_pc;
  logic [IW-1:0] inj_instr;
  logic          redirect_valid;
  logic [AW-1:0] redirect_pc;
  logic          exit_valid;
  logic [AW-1:0] exit_pc;
  logic [IW-1:0] exit_instr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  loop_fold_unit uut (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
    .ret_valid(ret_valid), .ret_pc(ret_pc), .ret_is_branch(ret_is_branch),
    .ret_taken(ret_taken), .ret_disp(ret_disp), .ret_instr(ret_instr),
    .ret_fall_instr(ret_fall_instr), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .inj_valid(inj_valid), .inj_pc(inj_pc), .inj_instr(inj_instr),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .exit_valid(exit_valid), .exit_pc(exit_pc), .exit_instr(exit_instr)
  );

  // {disp, taken, expect fold}
  localparam logic [9:0] QTAB [8] = '{
    {8'hFF, 1'b1, 1'b1},
    {8'hE0, 1'b1, 1'b1},
    {8'hDF, 1'b1, 1'b0},
    {8'h00, 1'b1, 1'b0},
    {8'h05, 1'b1, 1'b0},
    {8'hF6, 1'b0, 1'b0},
    {8'h80, 1'b1, 1'b0},
    {8'hF0, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] tgt(input logic [AW-1:0] pc, input logic [DW-1:0] d);
    int dv;
    dv = $signed(d);
    return pc + AW'(dv * 2);
  endfunction

  task automatic idle();
    @(negedge clk);
    flush_i = 0; ret_valid = 0; ret_is_branch = 0; ret_taken = 0; fetch_valid = 0;
  endtask

  task automatic retire(input logic [AW-1:0] pc, input logic br, input logic tk,
                        input logic [DW-1:0] d, input logic [IW-1:0] ins, input logic [IW-1:0] fall);
    @(negedge clk);
    flush_i = 0; fetch_valid = 0;
    ret_valid = 1; ret_pc = pc; ret_is_branch = br; ret_taken = tk;
    ret_disp = d; ret_instr = ins; ret_fall_instr = fall;
  endtask

  task automatic do_flush();
    @(negedge clk);
    ret_valid = 0; fetch_valid = 0; flush_i = 1;
  endtask

  // Drive a fetch and check the same-cycle response
  task automatic fetch_chk(input string req, input logic [AW-1:0] pc, input logic fv,
                           input logic exp_inj, input logic [AW-1:0] head, input logic [IW-1:0] hw);
    @(negedge clk);
    flush_i = 0; ret_valid = 0; fetch_valid = fv; fetch_pc = pc;
    #5;
    chk(req, 32'(inj_valid), 32'(exp_inj));
    chk(req, 32'(redirect_valid), 32'(exp_inj));
    if (exp_inj) begin
      chk(req, inj_pc, head);
      chk(req, 32'(inj_instr), 32'(hw));
      chk(req, redirect_pc, head + 2);
    end
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    #25;
    chk("R1", 32'(inj_valid), 0);
    chk("R1", 32'(exit_valid), 0);
    @(negedge clk); rst_n = 1;
    fetch_chk("R1", 32'h1000, 1, 0, 0, 0);

    // R2/R3 table: qualification of displacement and direction
    foreach (QTAB[i]) begin
      logic [DW-1:0] d;
      d = QTAB[i][9:2];
      do_flush();
      retire(32'h1000, 1, QTAB[i][1], d, 16'h1234, 16'h5555);
      retire(tgt(32'h1000, d), 0, 0, 0, 16'hA500 + 16'(i), 16'h0);
      fetch_chk(QTAB[i][1] ? "R2" : "R3", 32'h1000, 1, QTAB[i][0], tgt(32'h1000, d), 16'hA500 + 16'(i));
    end

    // R2: target would wrap below zero
    do_flush();
    retire(32'h0004, 1, 1, 8'hFC, 16'h1, 16'h2);
    retire(tgt(32'h0004, 8'hFC), 0, 0, 0, 16'h7777, 0);
    fetch_chk("R2", 32'h0004, 1, 0, 0, 0);

    // R4: captured but loop head not yet retired
    do_flush();
    retire(32'h1000, 1, 1, 8'hF8, 16'h1, 16'hBEEF);
    fetch_chk("R4", 32'h1000, 1, 0, 0, 0);
    retire(32'h0FF2, 0, 0, 0, 16'h1111, 0);
    fetch_chk("R4", 32'h1000, 1, 0, 0, 0);
    retire(32'h0FF0, 0, 0, 0, 16'hC0DE, 0);
    fetch_chk("R5", 32'h1000, 1, 1, 32'h0FF0, 16'hC0DE);

    // R6: no fold without a matching valid fetch
    fetch_chk("R6", 32'h1000, 0, 0, 0, 0);
    fetch_chk("R6", 32'h1002, 1, 0, 0, 0);
    fetch_chk("R6", 32'h0FF0, 1, 0, 0, 0);

    // R9: taken retire of the same branch keeps it armed
    retire(32'h1000, 1, 1, 8'hF8, 16'h1, 16'hBEEF);
    fetch_chk("R9", 32'h1000, 1, 1, 32'h0FF0, 16'hC0DE);

    // R7: untaken resolution exits the loop
    retire(32'h1000, 1, 0, 8'hF8, 16'h1, 16'h0);
    idle(); #5;
    chk("R7", 32'(exit_valid), 1);
    chk("R7", exit_pc, 32'h1002);
    chk("R7", 32'(exit_instr), 32'hBEEF);
    idle(); #5;
    chk("R7", 32'(exit_valid), 0);
    fetch_chk("R7", 32'h1000, 1, 0, 0, 0);

    // R9: a new branch replaces the entry
    retire(32'h1000, 1, 1, 8'hF8, 16'h1, 16'h2);
    retire(32'h0FF0, 0, 0, 0, 16'hC0DE, 0);
    retire(32'h2000, 1, 1, 8'hFC, 16'h1, 16'h3);
    retire(32'h1FF8, 0, 0, 0, 16'hD00D, 0);
    fetch_chk("R9", 32'h1000, 1, 0, 0, 0);
    fetch_chk("R9", 32'h2000, 1, 1, 32'h1FF8, 16'hD00D);

    // R8: flush empties an armed entry
    do_flush();
    fetch_chk("R8", 32'h2000, 1, 0, 0, 0);

    // R8: flush wins over a same-cycle capture
    @(negedge clk);
    fetch_valid = 0; flush_i = 1;
    ret_valid = 1; ret_pc = 32'h3000; ret_is_branch = 1; ret_taken = 1;
    ret_disp = 8'hFE; ret_instr = 16'h1; ret_fall_instr = 16'h2;
    retire(32'h2FFC, 0, 0, 0, 16'hE0E0, 0);
    fetch_chk("R8", 32'h3000, 1, 0, 0, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule